// File: doc/BRIEF.md
# Snooping MESI Line-State Controller

This block keeps the coherence state of every line in one private write-back cache that sits on a shared snooping bus. Each cycle it can take one event. The event is either from the local processor (load, store, eviction of a line) or snooped from the bus (another cache reading a line, or another cache claiming a line for writing). It looks up the addressed line in a small direct-mapped tag/state array. It works out the line's next state, writes it back to the array, and states which bus transactions the cache has to issue for this step: write the dirty line to memory (push), broadcast an invalidate, or fetch the line from memory (read).

When the processor misses on a load, an external shared-response input decides the fill state. If any other cache reports a copy, the line fills as Shared; otherwise it fills as Exclusive. When a miss lands on an index that holds a dirty line of another tag, the dirty victim is pushed before the new line is fetched. A probe event reports a line's state without changing it. Data storage, bus arbitration and memory ordering are handled outside this block.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid (state code I=0, S=1, E=2, M=3), and all result and transaction outputs are low.
- R2: A processor load (event code 0) that hits leaves the state unchanged and issues no transaction. A load that misses issues read and fills as Shared when `shr_rsp` is 1, or as Exclusive when it is 0.
- R3: A processor store (event code 1) that hits behaves as follows: from Shared it issues invalidate and moves to Modified; from Exclusive it moves to Modified with no transaction; from Modified it stays Modified with no transaction.
- R4: A processor store that misses issues both read and invalidate (read-for-ownership) and ends in Modified.
- R5: A load or store miss on an index that holds a Modified line with a different tag also issues push for that victim. A clean victim is overwritten with no push.
- R6: A snooped read (event code 3) that hits moves the line to Shared. It issues push only if the line was Modified.
- R7: A snooped invalidate (event code 4) that hits moves the line to Invalid. It issues push only if the line was Modified.
- R8: An eviction (event code 2) that hits moves the line to Invalid. It issues push only if the line was Modified.
- R9: A snoop or eviction that misses (tag mismatch or Invalid line) changes no line and issues no transaction.
- R10: A probe (event code 5, and the unused codes 6 and 7) reports the line's current state and hit flag, changes nothing and issues no transaction.
- R11: Results appear registered exactly one cycle after the event is presented. A cycle with no event gives `rsp_valid` low and no transaction. The address splits into the index (low `IDX_W` bits) and the tag (remaining bits).
- R12: `rsp_prev` gives the addressed line's state before the event (Invalid on a miss), and `rsp_state` gives its state after the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | An event is presented this cycle |
| ev_kind | input | 3 | Event code (0 load, 1 store, 2 evict, 3 snoop read, 4 snoop invalidate, 5-7 probe) |
| ev_addr | input | ADDR_W | Line address: tag above index |
| shr_rsp | input | 1 | Another cache holds the line (used on load miss) |
| rsp_valid | output | 1 | Result of last cycle's event is valid |
| rsp_hit | output | 1 | The addressed line was present |
| rsp_prev | output | 2 | Addressed line state before the event |
| rsp_state | output | 2 | Addressed line state after the event |
| bus_push | output | 1 | Write a dirty line back to memory |
| bus_inval | output | 1 | Broadcast an invalidate |
| bus_read | output | 1 | Fetch the line from memory |

## Verification
The bench steers random traffic onto a few indices and tags so that conflicting fills happen often. A design that dropped the victim push would lose dirty data without any sign of it at the line's own state. The bench also checks the Exclusive-to-Modified store, which must stay silent; a design that broadcast an invalidate there would only waste bus bandwidth, so that check catches it. Snoop reads on Modified lines must push before sharing, or memory would be left stale. Snoops and evictions that miss on a tag mismatch must leave the resident line alone; a design that matched on index only would destroy an unrelated line. Load misses are run with both values of the shared response to catch a fill state that is stuck at one value.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_t;

  typedef enum logic [2:0] {
    EV_LOAD   = 3'd0,
    EV_STORE  = 3'd1,
    EV_EVICT  = 3'd2,
    EV_SNRD   = 3'd3,
    EV_SNINV  = 3'd4,
    EV_PROBE  = 3'd5,
    EV_RSVD6  = 3'd6,
    EV_RSVD7  = 3'd7
  } ev_t;

  typedef struct packed {
    logic push;
    logic inval;
    logic fetch;
  } xact_t;
endpackage

// File: rtl/mesi_tag_store.sv
module mesi_tag_store
  import mesi_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output line_st_t         rd_state,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  line_st_t         wr_state
);
  localparam int LINES = 1 << IDX_W;

  // Tags carry no reset: plain array that maps onto distributed RAM.
  logic [TAG_W-1:0] tag_mem [LINES];
  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx] <= wr_tag;
  end
  assign rd_tag = tag_mem[rd_idx];

  // States are resettable flops, one register per line.
  line_st_t st_q [LINES];
  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst)
        st_q[g] <= ST_I;
      else if (wr_en && (wr_idx == IDX_W'(g)))
        st_q[g] <= wr_state;
    end
  end
  assign rd_state = st_q[rd_idx];

  // A line written this cycle holds the written state next cycle
  p_write_lands_r12: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (rd_idx == wr_idx)) |=> (rd_state == $past(wr_state)) || (rd_idx != $past(wr_idx)));
endmodule

// File: rtl/mesi_transition.sv
module mesi_transition
  import mesi_pkg::*;
(
  input  ev_t      kind,
  input  line_st_t stored,
  input  logic     tag_eq,
  input  logic     shr,
  output logic     hit,
  output line_st_t prev,
  output line_st_t nxt,
  output xact_t    xact,
  output logic     upd
);
  logic victim_dirty;

  always_comb begin
    hit          = (stored != ST_I) && tag_eq;
    victim_dirty = (stored == ST_M) && !tag_eq;
    prev         = hit ? stored : ST_I;
    nxt          = prev;
    xact         = '0;
    upd          = 1'b0;
    unique case (kind)
      EV_LOAD: begin
        if (!hit) begin
          xact.fetch = 1'b1;
          xact.push  = victim_dirty;
          nxt        = shr ? ST_S : ST_E;
          upd        = 1'b1;
        end
      end
      EV_STORE: begin
        upd = 1'b1;
        nxt = ST_M;
        if (hit) begin
          xact.inval = (stored == ST_S);
        end else begin
          xact.fetch = 1'b1;
          xact.inval = 1'b1;
          xact.push  = victim_dirty;
        end
      end
      EV_EVICT, EV_SNINV: begin
        if (hit) begin
          xact.push = (stored == ST_M);
          nxt       = ST_I;
          upd       = 1'b1;
        end
      end
      EV_SNRD: begin
        if (hit) begin
          xact.push = (stored == ST_M);
          nxt       = ST_S;
          upd       = 1'b1;
        end
      end
      default: begin
      end
    endcase
  end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  input  logic [2:0]        ev_kind,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic              shr_rsp,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [1:0]        rsp_prev,
  output logic [1:0]        rsp_state,
  output logic              bus_push,
  output logic              bus_inval,
  output logic              bus_read
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  assign idx = ev_addr[IDX_W-1:0];
  assign tag = ev_addr[ADDR_W-1:IDX_W];

  logic [TAG_W-1:0] st_tag;
  line_st_t         st_cur;
  ev_t              kind;
  logic             hit, upd;
  line_st_t         prev, nxt;
  xact_t            xact;

  assign kind = ev_t'(ev_kind);

  mesi_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (idx),
    .rd_tag   (st_tag),
    .rd_state (st_cur),
    .wr_en    (ev_valid && upd),
    .wr_idx   (idx),
    .wr_tag   (tag),
    .wr_state (nxt)
  );

  mesi_transition u_xfn (
    .kind   (kind),
    .stored (st_cur),
    .tag_eq (st_tag == tag),
    .shr    (shr_rsp),
    .hit    (hit),
    .prev   (prev),
    .nxt    (nxt),
    .xact   (xact),
    .upd    (upd)
  );

  logic snoop_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_prev  <= ST_I;
      rsp_state <= ST_I;
      bus_push  <= 1'b0;
      bus_inval <= 1'b0;
      bus_read  <= 1'b0;
      snoop_q   <= 1'b0;
    end else begin
      rsp_valid <= ev_valid;
      rsp_hit   <= ev_valid && hit;
      rsp_prev  <= ev_valid ? prev : ST_I;
      rsp_state <= ev_valid ? nxt  : ST_I;
      bus_push  <= ev_valid && xact.push;
      bus_inval <= ev_valid && xact.inval;
      bus_read  <= ev_valid && xact.fetch;
      snoop_q   <= ev_valid && (kind == EV_SNRD || kind == EV_SNINV);
    end
  end

  p_quiet_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !(bus_push || bus_inval || bus_read));
  p_fetch_only_miss_r2: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && bus_read) |-> !rsp_hit);
  p_inval_gives_mod_r3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && bus_inval) |-> (rsp_state == ST_M));
  p_dirty_leaves_push_r6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_prev == ST_M && rsp_state != ST_M) |-> bus_push);
  p_snoop_no_fetch_r9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && snoop_q) |-> !(bus_read || bus_inval));
endmodule

// File: tb/mesi_line_ctrl_bench.sv
module mesi_line_ctrl_bench;
  localparam int ADDR_W = 12;
  localparam int IDX_W  = 4;
  localparam int LINES  = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_valid = 1'b0;
  logic [2:0] ev_kind = 3'd0;
  logic [ADDR_W-1:0] ev_addr = '0;
  logic shr_rsp = 1'b0;
  logic rsp_valid, rsp_hit, bus_push, bus_inval, bus_read;
  logic [1:0] rsp_prev, rsp_state;

  always #2 clk = ~clk;

  mesi_line_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_mesi_line_ctrl (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_addr(ev_addr), .shr_rsp(shr_rsp), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_prev(rsp_prev), .rsp_state(rsp_state),
    .bus_push(bus_push), .bus_inval(bus_inval), .bus_read(bus_read));

  int n_tests = 0;
  int n_fail  = 0;
  int ref_st  [LINES];
  int ref_tag [LINES];

  // Reference transition derived from the requirements. States: I0 S1 E2 M3
  task automatic model(input int k, input int tg, input int ix, input bit sh,
                       output bit h, output int pv, output int nx,
                       output bit p, output bit iv, output bit rd, output string req);
    int cur = ref_st[ix];
    bit te  = (ref_tag[ix] == tg);
    bit vd  = (cur == 3) && !te;
    h = (cur != 0) && te; pv = h ? cur : 0; nx = pv; p = 0; iv = 0; rd = 0;
    case (k)
      0: if (h) req = "R2"; else begin rd = 1; p = vd; nx = sh ? 1 : 2; req = vd ? "R5" : "R2"; end
      1: if (h) begin iv = (cur == 1); nx = 3; req = "R3"; end
         else begin rd = 1; iv = 1; p = vd; nx = 3; req = vd ? "R5" : "R4"; end
      2: if (h) begin p = (cur == 3); nx = 0; req = "R8"; end else req = "R9";
      3: if (h) begin p = (cur == 3); nx = 1; req = "R6"; end else req = "R9";
      4: if (h) begin p = (cur == 3); nx = 0; req = "R7"; end else req = "R9";
      default: req = "R10";
    endcase
  endtask

  task automatic do_ev(input int k, input int tg, input int ix, input bit sh);
    bit h, p, iv, rd; int pv, nx; string req;
    model(k, tg, ix, sh, h, pv, nx, p, iv, rd, req);
    ev_valid = 1'b1; ev_kind = 3'(k); shr_rsp = sh;
    ev_addr = {(ADDR_W-IDX_W)'(tg), IDX_W'(ix)};
    @(negedge clk);
    n_tests++;
    if (!(rsp_valid === 1'b1 && rsp_hit === h && int'(rsp_prev) == pv &&
          int'(rsp_state) == nx && bus_push === p && bus_inval === iv && bus_read === rd)) begin
      n_fail++;
      $display("FAIL %s ev=%0d tag=%0d idx=%0d: got v%0b h%0b prev%0d st%0d p%0b i%0b r%0b exp v1 h%0b prev%0d st%0d p%0b i%0b r%0b",
               req, k, tg, ix, rsp_valid, rsp_hit, rsp_prev, rsp_state, bus_push, bus_inval, bus_read,
               h, pv, nx, p, iv, rd);
    end
    if (k <= 4 && (h || k <= 1)) begin
      if (k <= 1 || h) begin ref_st[ix] = nx; ref_tag[ix] = tg; end
    end
    ev_valid = 1'b0;
  endtask

  task automatic idle_check();
    ev_valid = 1'b0;
    @(negedge clk);
    n_tests++;
    if (rsp_valid !== 1'b0 || bus_push || bus_inval || bus_read) begin
      n_fail++;
      $display("FAIL R11 idle: got v%0b p%0b i%0b r%0b exp all 0", rsp_valid, bus_push, bus_inval, bus_read);
    end
  endtask

  initial begin
    for (int i = 0; i < LINES; i++) begin ref_st[i] = 0; ref_tag[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: outputs quiet after reset
    n_tests++;
    if (rsp_valid || bus_push || bus_inval || bus_read || rsp_state != 2'd0) begin
      n_fail++;
      $display("FAIL R1 reset outputs: got v%0b p%0b i%0b r%0b st%0d exp 0",
               rsp_valid, bus_push, bus_inval, bus_read, rsp_state);
    end
    // R1/R10: every line probes Invalid
    for (int i = 0; i < LINES; i++) do_ev(5, 0, i, 1'b0);
    // Directed corner cases on index 1
    do_ev(0, 3, 1, 1'b0);   // R2 load miss -> E
    do_ev(0, 3, 1, 1'b1);   // R2 load hit unchanged
    do_ev(1, 3, 1, 1'b0);   // R3 E->M silent
    do_ev(3, 3, 1, 1'b0);   // R6 M->S push
    do_ev(1, 3, 1, 1'b0);   // R3 S->M inval
    do_ev(1, 3, 1, 1'b0);   // R3 M stays
    do_ev(4, 5, 1, 1'b0);   // R9 snoop inval, tag mismatch
    do_ev(2, 5, 1, 1'b0);   // R9 evict, tag mismatch
    do_ev(5, 3, 1, 1'b0);   // R10 line still M
    do_ev(0, 5, 1, 1'b1);   // R5 dirty victim push, fill S
    do_ev(4, 5, 1, 1'b0);   // R7 S->I no push
    do_ev(4, 5, 1, 1'b0);   // R9 invalid line
    do_ev(1, 3, 1, 1'b0);   // R4 RFO -> M
    do_ev(4, 3, 1, 1'b0);   // R7 M->I push
    do_ev(1, 3, 1, 1'b0);   // R4
    do_ev(2, 3, 1, 1'b0);   // R8 M evict push
    do_ev(0, 3, 1, 1'b0);   // R2 fill E
    do_ev(3, 3, 1, 1'b0);   // R6 E->S silent
    do_ev(2, 3, 1, 1'b0);   // R8 clean evict silent
    do_ev(0, 3, 2, 1'b0);
    do_ev(1, 4, 2, 1'b0);   // R4 clean victim, no push
    do_ev(7, 4, 2, 1'b0);   // R10 unused code
    do_ev(6, 4, 2, 1'b0);   // R10 unused code
    idle_check();           // R11
    // Constrained random traffic
    void'($urandom(32'h5EED_0042));
    for (int n = 0; n < 3000; n++) begin
      if ($urandom % 16 == 0) idle_check();
      else do_ev(int'($urandom % 8), int'($urandom % 3), int'($urandom % 4), 1'($urandom));
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule